// File: doc/BRIEF.md
# E3 Maintenance Byte Monitor

This block watches the maintenance byte carried in every received E3 frame. A framer upstream hands it the byte together with a single-cycle strobe, once per frame. From that byte the monitor keeps the most recent payload type and compares it against a host-programmed expected type. A mismatch raises a sticky interrupt flag. It also filters the far-end receive failure (FERF) bit and the timing-marker bit through run-length persistence filters, so that one corrupted frame cannot flip either reported state.

Each filter counts consecutive frames that disagree with its current state. It flips the state once that run reaches 3 or 5 frames, and a configuration bit chooses which. The host sees everything through two byte-wide registers. A configuration/status register at offset 0x0E holds the captured type, the two run-length selects and the expected type. A status register at offset 0x0F holds the filtered FERF and timing-marker states and the mismatch flag.

Maintenance byte layout: bit 7 is FERF, bits 6..4 are the payload type, bit 3 is the timing marker, and bits 2..0 are ignored.

Top module: `e3_ma_monitor`

## Requirements
- R1: After reset, offset 0x0E reads 0x10 (FERF select = 1, all else 0), offset 0x0F reads 0x00, and all three status outputs are 0.
- R2: On each frame strobe the payload type (byte bits 6..4) is captured and appears in bits 7..5 of offset 0x0E from the next cycle on. Host writes to those bits have no effect.
- R3: With bit 4 of 0x0E at 0, FERF status sets after 3 consecutive frames with the FERF bit at 1, and clears after 3 consecutive frames with it at 0.
- R4: With bit 4 of 0x0E at 1, both setting and clearing of FERF status need 5 consecutive frames.
- R5: The timing-marker bit (byte bit 3) is accepted into the validated state after 3 consecutive agreeing frames when bit 3 of 0x0E is 0, and after 5 when it is 1.
- R6: Any frame whose filtered bit equals the current state restarts that filter's run count, so runs that are not consecutive never change the state.
- R7: A frame whose payload type differs from the expected type (bits 2..0 of 0x0E) sets the mismatch flag. The flag stays set while later frames match.
- R8: Reading offset 0x0F clears the mismatch flag on the next cycle. A mismatching frame in the same cycle as that read wins, and the flag stays set.
- R9: A host write that changes a run-length select bit restarts that filter's run count and leaves its current state unchanged.
- R10: Offset 0x0F reads {5'b0, mismatch, timing marker, FERF} in bits 7..0. Any other offset reads 0x00.
- R11: Filter counts and the captured type change only on frame strobes. Byte values presented without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe: ma_byte holds a new frame's maintenance byte |
| ma_byte | input | 8 | Maintenance byte of the current frame |
| reg_wr | input | 1 | Host register write enable |
| reg_rd | input | 1 | Host register read strobe (clears the flag when it reads 0x0F) |
| reg_addr | input | 8 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from reg_addr |
| ferf_status | output | 1 | Filtered far-end receive failure state |
| tmark_valid | output | 1 | Validated timing-marker state |
| pld_mismatch_irq | output | 1 | Sticky payload-type mismatch flag |

## Verification
The hardest case to reach from the ports is a select change in the middle of a run. The host write has to land after a partial run and before the run completes, and a wrong implementation can only be told apart by the exact frame on which the state flips afterwards. The directed stimulus builds two-frame runs, rewrites the select, and then counts out the full new run length, checking one frame short of it and then on it. The case where a mismatching frame coincides with a clearing read is driven in a single cycle on purpose. A long random phase then mixes strobes, writes and reads against the behavioural model.

// File: rtl/e3_ma_pkg.sv
package e3_ma_pkg;
  localparam int PT_W         = 3;
  localparam int MA_FERF_BIT  = 7;
  localparam int MA_PT_LSB    = 4;
  localparam int MA_TMARK_BIT = 3;
  localparam int SHORT_RUN    = 3;
  localparam int LONG_RUN     = 5;

  typedef logic [PT_W-1:0] pld_t;

  typedef struct packed {
    logic ferf_long;
    logic tmark_long;
    pld_t exp_pld;
  } cfg_t;
endpackage

// File: rtl/e3_persist_filter.sv
module e3_persist_filter #(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en,
  input  logic bit_in,
  input  logic long_sel,
  input  logic restart,
  output logic state_o
);
  localparam int CNT_W = $clog2(LONG_RUN + 1);

  logic [CNT_W-1:0] run_q, run_d;
  logic             state_q, state_d;
  logic [CNT_W-1:0] limit;

  assign limit = long_sel ? CNT_W'(LONG_RUN) : CNT_W'(SHORT_RUN);

  always_comb begin
    run_d   = run_q;
    state_d = state_q;
    if (restart) begin
      run_d = '0;
    end else if (frame_en) begin
      if (bit_in != state_q) begin
        if (run_q + 1'b1 == limit) begin
          state_d = bit_in;
          run_d   = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      state_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/e3_pld_check.sv
module e3_pld_check
  import e3_ma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en,
  input  pld_t pld_in,
  input  pld_t exp_pld,
  input  logic clr_req,
  output pld_t pld_o,
  output logic irq_o
);
  pld_t pld_q, pld_d;
  logic irq_q, irq_d;
  logic miss;

  assign miss = frame_en && (pld_in != exp_pld);

  always_comb begin
    pld_d = frame_en ? pld_in : pld_q;
    if (miss)         irq_d = 1'b1;
    else if (clr_req) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      pld_q <= pld_d;
      irq_q <= irq_d;
    end
  end

  assign pld_o = pld_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/e3_cfg_regs.sv
module e3_cfg_regs
  import e3_ma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output cfg_t       cfg_o,
  output logic       ferf_restart,
  output logic       tmark_restart
);
  cfg_t cfg_q, cfg_d, cfg_wr;

  assign cfg_wr = '{ferf_long: wdata[4], tmark_long: wdata[3], exp_pld: wdata[PT_W-1:0]};

  always_comb begin
    cfg_d = wr_en ? cfg_wr : cfg_q;
  end

  assign ferf_restart  = wr_en && (cfg_wr.ferf_long  != cfg_q.ferf_long);
  assign tmark_restart = wr_en && (cfg_wr.tmark_long != cfg_q.tmark_long);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{ferf_long: 1'b1, tmark_long: 1'b0, exp_pld: '0};
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/e3_ma_monitor.sv
module e3_ma_monitor
  import e3_ma_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter [ADDR_W-1:0] CFG_ADDR = 8'h0E,
  parameter [ADDR_W-1:0] STS_ADDR = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  logic [7:0]        ma_byte,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ferf_status,
  output logic              tmark_valid,
  output logic              pld_mismatch_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  cfg_t       cfg;
  pld_t       rx_pld;
  logic       cfg_wr_en, sts_rd_en;
  logic       ferf_rst, tmark_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign cfg_wr_en = reg_wr && (reg_addr == CFG_ADDR);
  assign sts_rd_en = reg_rd && (reg_addr == STS_ADDR);

  e3_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(cfg_wr_en), .wdata(reg_wdata),
    .cfg_o(cfg), .ferf_restart(ferf_rst), .tmark_restart(tmark_rst)
  );

  e3_persist_filter #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_ferf (
    .clk(clk), .rst_n(rst_core_n), .frame_en(frame_vld), .bit_in(ma_byte[MA_FERF_BIT]),
    .long_sel(cfg.ferf_long), .restart(ferf_rst), .state_o(ferf_status)
  );

  e3_persist_filter #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_tmark (
    .clk(clk), .rst_n(rst_core_n), .frame_en(frame_vld), .bit_in(ma_byte[MA_TMARK_BIT]),
    .long_sel(cfg.tmark_long), .restart(tmark_rst), .state_o(tmark_valid)
  );

  e3_pld_check u_pld (
    .clk(clk), .rst_n(rst_core_n), .frame_en(frame_vld),
    .pld_in(ma_byte[MA_PT_LSB +: PT_W]), .exp_pld(cfg.exp_pld), .clr_req(sts_rd_en),
    .pld_o(rx_pld), .irq_o(pld_mismatch_irq)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == CFG_ADDR)
      reg_rdata = {rx_pld, cfg.ferf_long, cfg.tmark_long, cfg.exp_pld};
    else if (reg_addr == STS_ADDR)
      reg_rdata = {5'b0, pld_mismatch_irq, tmark_valid, ferf_status};
  end
endmodule

// File: rtl/e3_ma_monitor_chk.sv
module e3_ma_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_vld,
  input logic [7:0] ma_byte,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic       ferf_status,
  input logic       tmark_valid,
  input logic       pld_mismatch_irq,
  input logic [2:0] exp_pld,
  input logic [2:0] rx_pld
);
  AST_FERF_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(ferf_status)); // R11
  AST_TMARK_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(tmark_valid)); // R11
  AST_PLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> rx_pld == $past(ma_byte[6:4])); // R2
  AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && ma_byte[6:4] != exp_pld) |=> pld_mismatch_irq); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h0F && !(frame_vld && ma_byte[6:4] != exp_pld)) |=> !pld_mismatch_irq); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_mismatch_irq && !(reg_rd && reg_addr == 8'h0F)) |=> pld_mismatch_irq); // R7
endmodule

bind e3_ma_monitor e3_ma_monitor_chk i_chk (
  .clk(clk), .rst_n(rst_core_n), .frame_vld(frame_vld), .ma_byte(ma_byte),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .ferf_status(ferf_status),
  .tmark_valid(tmark_valid), .pld_mismatch_irq(pld_mismatch_irq),
  .exp_pld(cfg.exp_pld), .rx_pld(rx_pld)
);

// File: tb/test_e3_ma_monitor.sv
module test_e3_ma_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_vld = 1'b0;
  logic [7:0] ma_byte = 8'h00;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ferf_status, tmark_valid, pld_mismatch_irq;

  int checks = 0, fails = 0;
  string phase_tag = "R1";
  bit cmp_on = 1'b0;

  // behavioural reference state
  int m_type, m_fsel, m_tsel, m_exp, m_ferf, m_tm, m_fcnt, m_tcnt, m_irq;
  int lim;
  bit set_f, clr_f;

  always #10 clk = ~clk;

  e3_ma_monitor i_e3_ma_monitor (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .ma_byte(ma_byte),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ferf_status(ferf_status), .tmark_valid(tmark_valid),
    .pld_mismatch_irq(pld_mismatch_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_type = 0; m_fsel = 1; m_tsel = 0; m_exp = 0;
      m_ferf = 0; m_tm = 0; m_fcnt = 0; m_tcnt = 0; m_irq = 0;
    end else begin
      set_f = 1'b0;
      if (frame_vld) begin
        if (int'(ma_byte[6:4]) != m_exp) set_f = 1'b1;
        m_type = ma_byte[6:4];
      end
      clr_f = reg_rd && reg_addr == 8'h0F;
      if (set_f) m_irq = 1; else if (clr_f) m_irq = 0;
      if (reg_wr && reg_addr == 8'h0E && int'(reg_wdata[4]) != m_fsel) m_fcnt = 0;
      else if (frame_vld) begin
        lim = m_fsel ? 5 : 3;
        if (int'(ma_byte[7]) != m_ferf) begin
          m_fcnt++;
          if (m_fcnt == lim) begin m_ferf = 1 - m_ferf; m_fcnt = 0; end
        end else m_fcnt = 0;
      end
      if (reg_wr && reg_addr == 8'h0E && int'(reg_wdata[3]) != m_tsel) m_tcnt = 0;
      else if (frame_vld) begin
        lim = m_tsel ? 5 : 3;
        if (int'(ma_byte[3]) != m_tm) begin
          m_tcnt++;
          if (m_tcnt == lim) begin m_tm = 1 - m_tm; m_tcnt = 0; end
        end else m_tcnt = 0;
      end
      if (reg_wr && reg_addr == 8'h0E) begin
        m_fsel = reg_wdata[4]; m_tsel = reg_wdata[3]; m_exp = reg_wdata[2:0];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({phase_tag, " ferf"}, ferf_status, m_ferf);
      chk({phase_tag, " tmark"}, tmark_valid, m_tm);
      chk({phase_tag, " irq"}, pld_mismatch_irq, m_irq);
      if (reg_addr == 8'h0E)
        chk("R2 rdata", reg_rdata, (m_type << 5) | (m_fsel << 4) | (m_tsel << 3) | m_exp);
      else if (reg_addr == 8'h0F)
        chk("R10 rdata", reg_rdata, (m_irq << 2) | (m_tm << 1) | m_ferf);
      else
        chk("R10 rdata", reg_rdata, 0);
    end
  end

  task automatic frame(input bit f, input bit tm, input int pt, input int gap = 1);
    @(negedge clk); #1;
    frame_vld = 1'b1; ma_byte = {f, 3'(pt), tm, 3'b101};
    @(negedge clk); #1;
    frame_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    #5 d = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    phase_tag = "R1";
    chk("R1 pins", {ferf_status, tmark_valid, pld_mismatch_irq}, 0);
    rd(8'h0E, d); chk("R1 cfg", d, 8'h10);
    rd(8'h0F, d); chk("R1 sts", d, 8'h00);
    // R4 five-frame declare
    phase_tag = "R4";
    repeat (4) frame(1, 0, 0);
    chk("R4 not yet", ferf_status, 0);
    frame(1, 0, 0);
    chk("R4 declared", ferf_status, 1);
    // R3 short mode clear; R9 state kept on select change
    phase_tag = "R9";
    wr(8'h0E, 8'h00);
    chk("R9 state kept", ferf_status, 1);
    phase_tag = "R3";
    repeat (2) frame(0, 0, 0);
    chk("R3 not yet", ferf_status, 1);
    frame(0, 0, 0);
    chk("R3 cleared", ferf_status, 0);
    // R6 broken run
    phase_tag = "R6";
    frame(1, 0, 0); frame(1, 0, 0); frame(0, 0, 0); frame(1, 0, 0); frame(1, 0, 0);
    chk("R6 broken run", ferf_status, 0);
    frame(1, 0, 0);
    chk("R6 full run", ferf_status, 1);
    // R9 select change mid-run
    phase_tag = "R9";
    frame(0, 0, 0); frame(0, 0, 0);
    wr(8'h0E, 8'h10);
    repeat (4) frame(0, 0, 0);
    chk("R9 restarted", ferf_status, 1);
    frame(0, 0, 0);
    chk("R9 after five", ferf_status, 0);
    // R11 no strobe
    phase_tag = "R11";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1 ma_byte = 8'hFF ^ 8'(i);
    end
    chk("R11 idle ferf", ferf_status, 0);
    rd(8'h0E, d); chk("R11 type held", d[7:5], 0);
    // R5 timing marker
    phase_tag = "R5";
    frame(0, 1, 0); frame(0, 1, 0);
    chk("R5 short not yet", tmark_valid, 0);
    frame(0, 1, 0);
    chk("R5 short", tmark_valid, 1);
    wr(8'h0E, 8'h18);
    repeat (4) frame(0, 0, 0);
    chk("R5 long not yet", tmark_valid, 1);
    frame(0, 0, 0);
    chk("R5 long", tmark_valid, 0);
    // R7 sticky mismatch
    phase_tag = "R7";
    frame(0, 0, 3);
    chk("R7 set", pld_mismatch_irq, 1);
    frame(0, 0, 0); frame(0, 0, 0);
    chk("R7 sticky", pld_mismatch_irq, 1);
    phase_tag = "R8";
    rd(8'h0F, d); chk("R8 read shows flag", d[2], 1);
    chk("R8 cleared", pld_mismatch_irq, 0);
    // R8 set wins over clear
    @(negedge clk); #1;
    frame_vld = 1'b1; ma_byte = {1'b0, 3'd5, 1'b0, 3'b000}; reg_rd = 1'b1; reg_addr = 8'h0F;
    @(negedge clk); #1;
    frame_vld = 1'b0; reg_rd = 1'b0;
    chk("R8 set wins", pld_mismatch_irq, 1);
    rd(8'h0F, d);
    chk("R8 cleared again", pld_mismatch_irq, 0);
    // R2 read-only type field, R10 unmapped offset
    phase_tag = "R2";
    wr(8'h0E, 8'hF3);
    rd(8'h0E, d); chk("R2 ro type", d, 8'hB3);
    rd(8'h05, d); chk("R10 unmapped", d, 8'h00);
    // mixed random traffic
    phase_tag = "R3/R4/R5/R6";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      frame_vld = ($urandom_range(0, 2) == 0);
      ma_byte = 8'($urandom);
      if ($urandom_range(0, 3) == 0) ma_byte[7] = ma_byte[3];
      reg_wr = ($urandom_range(0, 29) == 0);
      reg_rd = ($urandom_range(0, 9) == 0);
      reg_addr = 8'h0D + 8'($urandom_range(0, 3));
      reg_wdata = 8'($urandom);
    end
    @(negedge clk); #1;
    frame_vld = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule